// File: doc/BRIEF.md
# Dual-Mode Parallel Host Register Port

This block is the slave side of an 8-bit parallel register-access port. It serves one of two bus timings. In the first timing, separate active-low write and read strobes each start an access. In the second, a direction level chooses read or write, and one active-low data strobe starts the access. In both timings the address comes in on a shared bus and is latched when the address-latch input falls. The port gives access to a small internal file of 15 byte-wide registers at addresses 0 to 14.

All strobes pass through a two-stage synchroniser into the block clock. Each access is committed exactly once, on the synchronised falling edge of its strobe. The completion handshake has the opposite sense in the two timings. When the `hw_mode` pin is high, the whole port is disabled and the chip is controlled through its pins.

The data bus is split into input, output and output-enable lanes. A pad ring combines them into the bidirectional pins. All inputs are control-level strobes, so there is no stream interface and no back-pressure. The host paces each cycle by holding its strobe until it sees the handshake.

Top module: `host_port_if`

## Requirements
- R1: While `hw_mode` is 1, no strobe writes a register, `host_d_oe` stays 0, and `rdy_ack` stays at its idle level.
- R2: While `cs_n` is high, no strobe on `wr_rw` or `rd_ds` starts an access. The registers keep their contents and `rdy_ack` stays idle.
- R3: With `moto_mode`=0 and `cs_n` low, a falling edge on `wr_rw` (write strobe, active low) writes `host_d_i` into the register at the latched address.
- R4: With `moto_mode`=0 and `cs_n` low, a falling edge on `rd_ds` (read strobe, active low) places the contents of the latched register on `host_d_o`. `host_d_oe` is 1 until the strobe or `cs_n` is released.
- R5: With `moto_mode`=1 and `cs_n` low, a falling edge on `rd_ds` (data strobe) starts the access. It is a read if `wr_rw` is 1 and a write if `wr_rw` is 0.
- R6: The address on `addr` is captured when `ale_as` falls. Later changes on `addr` do not affect the access.
- R7: `rdy_ack` is active from the commit until the strobe is released. With `moto_mode`=0 it is active high and idles at 0. With `moto_mode`=1 it is active low and idles at 1.
- R8: A read of any address from 15 to 255 returns 0x00. A write to such an address changes no register.
- R9: Each strobe pulse commits once. With `moto_mode`=0, data that changes on `host_d_i` while the write strobe is still low is not written.
- R10: After reset, all registers hold 0x00, `host_d_oe` is 0, and `rdy_ack` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1 disables the host port (pin-control mode) |
| moto_mode | input | 1 | 0 selects separate read and write strobes; 1 selects direction plus data strobe |
| cs_n | input | 1 | Chip select, active low |
| wr_rw | input | 1 | Write strobe (mode 0) or direction, 1 for read (mode 1) |
| rd_ds | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| ale_as | input | 1 | Address latch; address is captured on its falling edge |
| addr | input | 8 | Register address |
| host_d_i | input | 8 | Write data from the pad |
| host_d_o | output | 8 | Read data to the pad |
| host_d_oe | output | 1 | Pad output enable for read data |
| rdy_ack | output | 1 | Completion handshake, polarity set by `moto_mode` |

## Verification
A strobe change takes two synchroniser stages and one edge-detect register. Every result therefore appears after the third rising clock edge that follows the pin change. This covers the register write, the read data, `host_d_oe`, and both the rise and the fall of `rdy_ack`. The bench drives every pin on a falling clock edge and waits five clock periods before it samples. This margin covers the three-edge latency with room to spare. Because the handshake is checked both while the strobe is held and after it is released, a wrong polarity or a missing release is caught. Read-backs through the normal bus cycle expose the register state after each write, ignored write and unmapped access.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic {
    BUS_SPLIT_STROBE = 1'b0,
    BUS_DIR_STROBE   = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic cs_n;
    logic wr_rw;
    logic rd_ds;
    logic ale;
  } pin_bundle_t;

  localparam int PIN_BITS = $bits(pin_bundle_t);
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpi_cycle_decode.sv
module hpi_cycle_decode #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_mode,
  input  logic          moto_mode,
  input  hpi_pkg::pin_bundle_t pins_s,
  input  logic [AW-1:0] addr_raw,
  output logic [AW-1:0] addr_q,
  output logic          wr_go,
  output logic          rd_go,
  output logic          busy_q,
  output logic          rd_busy_q
);
  import hpi_pkg::*;

  pin_bundle_t prev_q;
  logic host_ok, wr_fall, rd_fall, ale_fall, strobe_held, release_now;
  bus_mode_e mode;

  assign mode     = bus_mode_e'(moto_mode);
  assign host_ok  = ~hw_mode & ~pins_s.cs_n;
  assign wr_fall  = prev_q.wr_rw & ~pins_s.wr_rw;
  assign rd_fall  = prev_q.rd_ds & ~pins_s.rd_ds;
  assign ale_fall = prev_q.ale & ~pins_s.ale;

  always_comb begin
    wr_go = 1'b0;
    rd_go = 1'b0;
    strobe_held = 1'b0;
    unique case (mode)
      BUS_SPLIT_STROBE: begin
        wr_go = host_ok & wr_fall;
        rd_go = host_ok & rd_fall & ~wr_fall;
        strobe_held = ~pins_s.wr_rw | ~pins_s.rd_ds;
      end
      BUS_DIR_STROBE: begin
        wr_go = host_ok & rd_fall & ~pins_s.wr_rw;
        rd_go = host_ok & rd_fall & pins_s.wr_rw;
        strobe_held = ~pins_s.rd_ds;
      end
      default: ;
    endcase
  end

  assign release_now = ~strobe_held | pins_s.cs_n | hw_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '1;
      addr_q    <= '0;
      busy_q    <= 1'b0;
      rd_busy_q <= 1'b0;
    end else begin
      prev_q <= pins_s;
      if (ale_fall && !hw_mode) addr_q <= addr_raw;
      if (wr_go || rd_go) begin
        busy_q    <= 1'b1;
        rd_busy_q <= rd_go;
      end else if (release_now) begin
        busy_q    <= 1'b0;
        rd_busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpi_regfile.sv
module hpi_regfile #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int NUM_REGS = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wdata,
  input  logic                   rd_load,
  output logic [DW-1:0]          rdata_q,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  logic [DW-1:0] regs [NUM_REGS];
  logic [DW-1:0] rd_mux;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [AW-1:0] MY_ADDR = AW'(i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else if (wr_en && addr == MY_ADDR) regs[i] <= wdata;
      end
      assign regs_flat[i*DW +: DW] = regs[i];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == AW'(i)) rd_mux = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_load) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/host_port_if.sv
module host_port_if #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int NUM_REGS    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_mode,
  input  logic          moto_mode,
  input  logic          cs_n,
  input  logic          wr_rw,
  input  logic          rd_ds,
  input  logic          ale_as,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe,
  output logic          rdy_ack
);
  import hpi_pkg::*;

  localparam logic [PIN_BITS-1:0] PIN_IDLE = 4'b1110;

  pin_bundle_t pins_raw, pins_s;
  logic [AW-1:0] addr_q;
  logic wr_go, rd_go, busy_q, rd_busy_q;
  logic [NUM_REGS*DW-1:0] regs_flat;

  assign pins_raw = '{cs_n: cs_n, wr_rw: wr_rw, rd_ds: rd_ds, ale: ale_as};

  hpi_sync #(.WIDTH(PIN_BITS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  hpi_cycle_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .moto_mode(moto_mode),
    .pins_s(pins_s), .addr_raw(addr), .addr_q(addr_q),
    .wr_go(wr_go), .rd_go(rd_go), .busy_q(busy_q), .rd_busy_q(rd_busy_q)
  );

  hpi_regfile #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .addr(addr_q), .wr_en(wr_go), .wdata(host_d_i),
    .rd_load(rd_go), .rdata_q(host_d_o), .regs_flat(regs_flat)
  );

  assign host_d_oe = rd_busy_q;
  assign rdy_ack   = moto_mode ? ~busy_q : busy_q;
endmodule

// File: rtl/hpi_checker.sv
module hpi_checker #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int NUM_REGS = 15
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hw_mode,
  input logic                   moto_mode,
  input logic                   cs_sync,
  input logic                   wr_go,
  input logic [AW-1:0]          addr_q,
  input logic [NUM_REGS*DW-1:0] regs_flat,
  input logic [DW-1:0]          host_d_o,
  input logic                   host_d_oe,
  input logic                   rdy_ack
);
  a_r2_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    host_d_oe |-> !$past(cs_sync));

  a_r1_hw_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hw_mode) && hw_mode) |-> (!host_d_oe && rdy_ack == moto_mode));

  a_r9_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);

  a_r3_regs_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_go) |-> $stable(regs_flat));

  a_r7_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    host_d_oe |-> (rdy_ack == !moto_mode));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_d_oe && addr_q >= AW'(NUM_REGS)) |-> (host_d_o == '0));
endmodule

bind host_port_if hpi_checker #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .moto_mode(moto_mode),
  .cs_sync(pins_s.cs_n), .wr_go(wr_go), .addr_q(addr_q), .regs_flat(regs_flat),
  .host_d_o(host_d_o), .host_d_oe(host_d_oe), .rdy_ack(rdy_ack)
);

// File: tb/host_port_if_tb.sv
module host_port_if_tb;
  localparam time HALF = 2ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_mode = 1'b0, moto_mode = 1'b0;
  logic cs_n = 1'b1, wr_rw = 1'b1, rd_ds = 1'b1, ale_as = 1'b0;
  logic [7:0] addr = '0, host_d_i = '0;
  logic [7:0] host_d_o;
  logic host_d_oe, rdy_ack;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #HALF clk = ~clk;

  host_port_if u_dut (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .moto_mode(moto_mode),
    .cs_n(cs_n), .wr_rw(wr_rw), .rd_ds(rd_ds), .ale_as(ale_as), .addr(addr),
    .host_d_i(host_d_i), .host_d_o(host_d_o), .host_d_oe(host_d_oe), .rdy_ack(rdy_ack)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_addr(logic [7:0] a);
    addr = a; ale_as = 1'b1; gap(4);
    ale_as = 1'b0; gap(4);
  endtask

  function automatic logic idle_ack();
    return moto_mode;
  endfunction

  task automatic do_write(logic [7:0] a, logic [7:0] d, string tag);
    latch_addr(a);
    host_d_i = d;
    if (moto_mode) begin wr_rw = 1'b0; gap(4); end
    cs_n = 1'b0; gap(2);
    if (moto_mode) rd_ds = 1'b0; else wr_rw = 1'b0;
    gap(5);
    chk({tag, " R7 ack during write"}, 8'(rdy_ack), 8'(!idle_ack()));
    if (moto_mode) rd_ds = 1'b1; else wr_rw = 1'b1;
    gap(5);
    chk({tag, " R7 ack released"}, 8'(rdy_ack), 8'(idle_ack()));
    cs_n = 1'b1; wr_rw = 1'b1; gap(2);
  endtask

  task automatic do_read(logic [7:0] a, logic [7:0] exp, string tag);
    latch_addr(a);
    cs_n = 1'b0; gap(2);
    rd_ds = 1'b0; gap(5);
    chk({tag, " R4 oe"}, 8'(host_d_oe), 8'h01);
    chk({tag, " data"}, host_d_o, exp);
    chk({tag, " R7 ack during read"}, 8'(rdy_ack), 8'(!idle_ack()));
    rd_ds = 1'b1; gap(5);
    chk({tag, " R4 oe released"}, 8'(host_d_oe), 8'h00);
    cs_n = 1'b1; gap(2);
  endtask

  task automatic t_reset();
    chk("R10 oe after reset", 8'(host_d_oe), 8'h00);
    chk("R10 rdy idle after reset", 8'(rdy_ack), 8'h00);
    do_read(8'd7, 8'h00, "R10 reg7 after reset");
  endtask

  task automatic t_split_rw();
    do_write(8'd2, 8'h5A, "R3 w2");
    do_write(8'd14, 8'hC3, "R3 w14");
    do_write(8'd0, 8'h11, "R3 w0");
    do_read(8'd2, 8'h5A, "R4 r2");
    do_read(8'd14, 8'hC3, "R4 r14");
    do_read(8'd0, 8'h11, "R4 r0");
  endtask

  task automatic t_unmapped();
    do_write(8'd15, 8'hFF, "R8 w15");
    do_read(8'd15, 8'h00, "R8 r15");
    do_read(8'd200, 8'h00, "R8 r200");
    do_read(8'd14, 8'hC3, "R8 r14 kept");
    do_read(8'd0, 8'h11, "R8 r0 kept");
  endtask

  task automatic t_addr_latch();
    latch_addr(8'd2);
    addr = 8'd0;
    cs_n = 1'b0; gap(2);
    rd_ds = 1'b0; gap(5);
    chk("R6 latched address used", host_d_o, 8'h5A);
    rd_ds = 1'b1; gap(5);
    cs_n = 1'b1; gap(2);
  endtask

  task automatic t_no_cs();
    latch_addr(8'd2);
    host_d_i = 8'h00;
    wr_rw = 1'b0; gap(5);
    chk("R2 no ack without cs", 8'(rdy_ack), 8'h00);
    wr_rw = 1'b1; gap(2);
    rd_ds = 1'b0; gap(5);
    chk("R2 no drive without cs", 8'(host_d_oe), 8'h00);
    rd_ds = 1'b1; gap(3);
    do_read(8'd2, 8'h5A, "R2 r2 kept");
  endtask

  task automatic t_single_commit();
    latch_addr(8'd5);
    host_d_i = 8'h3C;
    cs_n = 1'b0; gap(2);
    wr_rw = 1'b0; gap(5);
    host_d_i = 8'hE1; gap(6);
    wr_rw = 1'b1; gap(5);
    cs_n = 1'b1; gap(2);
    do_read(8'd5, 8'h3C, "R9 r5 first value");
  endtask

  task automatic t_dir_strobe();
    moto_mode = 1'b1; gap(3);
    chk("R7 dir-strobe idle ack", 8'(rdy_ack), 8'h01);
    do_write(8'd9, 8'h77, "R5 w9");
    do_write(8'd3, 8'hA5, "R5 w3");
    do_read(8'd9, 8'h77, "R5 r9");
    do_read(8'd3, 8'hA5, "R5 r3");
  endtask

  task automatic t_hw_mode();
    hw_mode = 1'b1; gap(3);
    latch_addr(8'd9);
    host_d_i = 8'h00;
    wr_rw = 1'b0; gap(4);
    cs_n = 1'b0; gap(2);
    rd_ds = 1'b0; gap(5);
    chk("R1 ack idle in hw mode", 8'(rdy_ack), 8'h01);
    rd_ds = 1'b1; gap(3);
    wr_rw = 1'b1; gap(3);
    rd_ds = 1'b0; gap(5);
    chk("R1 no drive in hw mode", 8'(host_d_oe), 8'h00);
    rd_ds = 1'b1; cs_n = 1'b1; gap(3);
    hw_mode = 1'b0; gap(3);
    do_read(8'd9, 8'h77, "R1 r9 kept");
    moto_mode = 1'b0; gap(3);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    gap(4);
    rst_n = 1'b1;
    gap(3);
    t_reset();
    t_split_rw();
    t_unmapped();
    t_addr_latch();
    t_no_cs();
    t_single_commit();
    t_dir_strobe();
    t_hw_mode();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule